// File: doc/BRIEF.md
# Direct Digital Synthesis Waveform Core

This core turns a master clock into a periodic waveform by direct digital synthesis. A 28-bit phase accumulator advances by a tuning word on every clock. Its top 12 bits, plus a 12-bit phase offset, form the instantaneous phase. From that phase the core builds a sine, a triangle or a square sample. Two tuning words and two phase offsets are held at the inputs. Separate select pins pick one of each on any cycle, so frequency-shift or phase-shift keying comes down to toggling a pin.

The sample word is unsigned offset-binary, with mid-scale at 512 for the default 10-bit width. The sine comes from a quarter-wave table that the code computes at elaboration with a rational approximation, and the other three quadrants are folded from it. A separate 1-bit square output follows the phase MSB at full rate, or at half rate through a toggle. A sleep pin mutes the sample path and leaves the square pin running. A core-reset pin clears the accumulator and parks the sample at mid-scale. A halt pin freezes the accumulator.

The sample word is a free-running stream: it is updated on every clock and has no valid/ready pair, because a synthesizer cannot be stalled without distorting its frequency. A consumer that is not ready simply misses samples, and no back-pressure reaches the core. Every control input is a plain level.

Top module: `dds_wave_core`

## Requirements
- R1: While rst_n is low, or one clock after core_reset_i is sampled high, the accumulator is zero, sample_o is mid-scale (512) and square_o is 0. After core_reset_i is released with both tuning words zero, the phase equals the selected offset.
- R2: Each clock, the accumulator adds the selected tuning word modulo 2^28. With a power-of-two word F, the phase MSB, and with it square_o at full rate, has a period of exactly 2^28/F clocks (16 clocks for F = 2^24, 64 clocks for F = 2^22).
- R3: freq_sel_i = 0 selects freq0_i and freq_sel_i = 1 selects freq1_i as the accumulator step.
- R4: phase_sel_i = 0 selects phase0_i and phase_sel_i = 1 selects phase1_i. The phase is accumulator bits 27:16 plus the offset, modulo 4096.
- R5: While clk_halt_i is 1, the accumulator does not advance, so sample_o and square_o stay constant.
- R6: In sine mode (square_en_i = 0, tri_sel_i = 0, dac_sleep_i = 0), sample_o is 512 at phase 0, between 1018 and 1023 at phase 0x400, and between 0 and 5 at phase 0xC00.
- R7: In sine mode, the samples for phase p and phase p + 0x800 sum to exactly 1024.
- R8: In triangle mode (tri_sel_i = 1, square_en_i = 0), sample_o is phase[10:1] for a phase below 0x800 and (~phase)[10:1] otherwise. This gives 0 at phase 0, 512 at 0x400, 1023 at 0x7FF, 511 at 0xC00 and 256 at 0x200.
- R9: With square_en_i = 1 (and dac_sleep_i = 0), sample_o is 1023 when phase bit 11 is 1 and 0 when it is 0, whatever tri_sel_i is.
- R10: square_o is the registered phase MSB when square_full_i = 1. When square_full_i = 0 it is a register that toggles on each rising edge of that MSB, so its period is twice the full-rate period (32 clocks for F = 2^24).
- R11: dac_sleep_i = 1 forces sample_o to 0 over every wave mode and leaves square_o running at its normal rate.
- R12: sample_o is registered. A change of the selected phase offset appears on sample_o after exactly one rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| freq0_i | input | 28 | Tuning word 0 |
| freq1_i | input | 28 | Tuning word 1 |
| phase0_i | input | 12 | Phase offset 0 |
| phase1_i | input | 12 | Phase offset 1 |
| freq_sel_i | input | 1 | Tuning word select (1 = word 1) |
| phase_sel_i | input | 1 | Phase offset select (1 = offset 1) |
| core_reset_i | input | 1 | Synchronous core reset, active high |
| clk_halt_i | input | 1 | Freeze the accumulator |
| dac_sleep_i | input | 1 | Mute the sample path to 0 |
| square_en_i | input | 1 | Square wave on the sample word |
| tri_sel_i | input | 1 | Triangle (1) or sine (0) when square is off |
| square_full_i | input | 1 | Full-rate (1) or half-rate (0) square_o |
| sample_o | output | 10 | Offset-binary sample |
| square_o | output | 1 | Square output |

## Verification
The assertions assume that every control pin is a clean level that changes only between clock edges. They also check each effect one clock after the controls that cause it, so a pin toggled at every edge still has defined expectations. The bench drives every input on the falling edge and samples on the falling edge as well. For the static waveform points it holds both tuning words at zero after a core reset, so the phase equals the chosen offset. Frequency checks use power-of-two tuning words only, so that the MSB period is an exact whole number of clocks.

// File: rtl/dds_pkg.sv
package dds_pkg;
  typedef enum logic [1:0] {
    SHP_SINE = 2'd0,
    SHP_TRI  = 2'd1,
    SHP_SQR  = 2'd2,
    SHP_MUTE = 2'd3
  } shape_e;
endpackage

// File: rtl/dds_phase_acc.sv
module dds_phase_acc #(
  parameter int ACC_W   = 28,
  parameter int PHASE_W = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr_i,
  input  logic               halt_i,
  input  logic [ACC_W-1:0]   freq0_i,
  input  logic [ACC_W-1:0]   freq1_i,
  input  logic               fsel_i,
  input  logic [PHASE_W-1:0] off0_i,
  input  logic [PHASE_W-1:0] off1_i,
  input  logic               psel_i,
  output logic [PHASE_W-1:0] phase_o
);
  logic [ACC_W-1:0]   acc_q;
  logic [ACC_W-1:0]   step;
  logic [PHASE_W-1:0] offset;

  assign step   = fsel_i ? freq1_i : freq0_i;
  assign offset = psel_i ? off1_i : off0_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       acc_q <= '0;
    else if (clr_i)   acc_q <= '0;
    else if (!halt_i) acc_q <= acc_q + step;
  end

  assign phase_o = acc_q[ACC_W-1 -: PHASE_W] + offset;

  // R1
  acc_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (acc_q == '0));

  // R5
  halt_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (halt_i && !clr_i) |=> $stable(acc_q));

  // R2
  acc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!halt_i && !clr_i) |=> (acc_q == $past(acc_q) + $past(fsel_i ? freq1_i : freq0_i)));
endmodule

// File: rtl/dds_sine_quarter.sv
module dds_sine_quarter #(
  parameter int PHASE_W  = 12,
  parameter int LUT_AW   = 10,
  parameter int SAMPLE_W = 10
) (
  input  logic [PHASE_W-1:0]  phase_i,
  output logic [SAMPLE_W-1:0] sine_o
);
  localparam int QN  = 1 << LUT_AW;
  localparam int AMP = (1 << (SAMPLE_W - 1)) - 1;
  localparam logic [SAMPLE_W-1:0] MID = {1'b1, {(SAMPLE_W-1){1'b0}}};

  // Rational sine approximation over a quarter period, evaluated at elaboration.
  function automatic logic [SAMPLE_W-2:0] quarter_val(input int i);
    longint x, h, num, den;
    x   = longint'(i);
    h   = 2 * longint'(QN);
    num = 16 * x * (h - x) * longint'(AMP);
    den = 5 * h * h - 4 * x * (h - x);
    return (SAMPLE_W-1)'((num + den / 2) / den);
  endfunction

  logic [SAMPLE_W-2:0] lut [QN];

  for (genvar g = 0; g < QN; g++) begin : g_lut
    assign lut[g] = quarter_val(g);
  end

  logic [LUT_AW-1:0]   addr;
  logic [LUT_AW-1:0]   idx;
  logic [SAMPLE_W-2:0] mag;

  assign addr = phase_i[PHASE_W-3 -: LUT_AW];
  assign idx  = phase_i[PHASE_W-2] ? ~addr : addr;
  assign mag  = lut[idx];

  always_comb begin
    if (phase_i[PHASE_W-1]) sine_o = MID - {1'b0, mag};
    else                    sine_o = MID + {1'b0, mag};
  end
endmodule

// File: rtl/dds_square_gen.sv
module dds_square_gen (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic msb_i,
  input  logic full_i,
  output logic sq_o
);
  logic msb_q;
  logic half_q;
  logic msb_rise;

  assign msb_rise = msb_i & ~msb_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      msb_q  <= 1'b0;
      half_q <= 1'b0;
    end else if (clr_i) begin
      msb_q  <= 1'b0;
      half_q <= 1'b0;
    end else begin
      msb_q  <= msb_i;
      half_q <= half_q ^ msb_rise;
    end
  end

  assign sq_o = full_i ? msb_q : half_q;

  // R10
  half_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && msb_i && !msb_q) |=> (half_q != $past(half_q)));

  // R10
  half_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && !(msb_i && !msb_q)) |=> $stable(half_q));
endmodule

// File: rtl/dds_wave_core.sv
module dds_wave_core #(
  parameter int ACC_W    = 28,
  parameter int PHASE_W  = 12,
  parameter int SAMPLE_W = 10,
  parameter int LUT_AW   = PHASE_W - 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ACC_W-1:0]    freq0_i,
  input  logic [ACC_W-1:0]    freq1_i,
  input  logic [PHASE_W-1:0]  phase0_i,
  input  logic [PHASE_W-1:0]  phase1_i,
  input  logic                freq_sel_i,
  input  logic                phase_sel_i,
  input  logic                core_reset_i,
  input  logic                clk_halt_i,
  input  logic                dac_sleep_i,
  input  logic                square_en_i,
  input  logic                tri_sel_i,
  input  logic                square_full_i,
  output logic [SAMPLE_W-1:0] sample_o,
  output logic                square_o
);
  import dds_pkg::*;

  localparam logic [SAMPLE_W-1:0] MID   = {1'b1, {(SAMPLE_W-1){1'b0}}};
  localparam int                  TRI_SH = PHASE_W - 1 - SAMPLE_W;

  logic [PHASE_W-1:0]  phase;
  logic [SAMPLE_W-1:0] sine_val;
  logic [PHASE_W-2:0]  fold;
  logic [SAMPLE_W-1:0] tri_val;
  logic [SAMPLE_W-1:0] sqr_val;
  shape_e              shape;
  logic [SAMPLE_W-1:0] next_sample;

  dds_phase_acc #(.ACC_W(ACC_W), .PHASE_W(PHASE_W)) u_acc (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr_i   (core_reset_i),
    .halt_i  (clk_halt_i),
    .freq0_i (freq0_i),
    .freq1_i (freq1_i),
    .fsel_i  (freq_sel_i),
    .off0_i  (phase0_i),
    .off1_i  (phase1_i),
    .psel_i  (phase_sel_i),
    .phase_o (phase)
  );

  dds_sine_quarter #(.PHASE_W(PHASE_W), .LUT_AW(LUT_AW), .SAMPLE_W(SAMPLE_W)) u_sine (
    .phase_i (phase),
    .sine_o  (sine_val)
  );

  dds_square_gen u_sqr (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr_i  (core_reset_i),
    .msb_i  (phase[PHASE_W-1]),
    .full_i (square_full_i),
    .sq_o   (square_o)
  );

  assign fold    = phase[PHASE_W-1] ? ~phase[PHASE_W-2:0] : phase[PHASE_W-2:0];
  assign tri_val = SAMPLE_W'(fold >> TRI_SH);
  assign sqr_val = {SAMPLE_W{phase[PHASE_W-1]}};

  always_comb begin
    if (dac_sleep_i)      shape = SHP_MUTE;
    else if (square_en_i) shape = SHP_SQR;
    else if (tri_sel_i)   shape = SHP_TRI;
    else                  shape = SHP_SINE;
  end

  always_comb begin
    unique case (shape)
      SHP_SINE: next_sample = sine_val;
      SHP_TRI:  next_sample = tri_val;
      SHP_SQR:  next_sample = sqr_val;
      default:  next_sample = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            sample_o <= MID;
    else if (core_reset_i) sample_o <= MID;
    else                   sample_o <= next_sample;
  end

  // R1
  core_reset_mid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    core_reset_i |=> (sample_o == MID && !square_o));

  // R11
  sleep_mute_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dac_sleep_i && !core_reset_i) |=> (sample_o == '0));

  // R9
  square_rail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (square_en_i && !dac_sleep_i && !core_reset_i) |=> (sample_o == '0 || sample_o == '1));
endmodule

// File: tb/tb_dds_wave_core.sv
module tb_dds_wave_core;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [27:0] freq0, freq1;
  logic [11:0] ph0, ph1;
  logic        fsel, psel, creset, halt, sleep, sqen, trisel, sqfull;
  logic [9:0]  sample;
  logic        square;

  int vectors = 0;
  int miscompares = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  dds_wave_core dut (
    .clk(clk), .rst_n(rst_n),
    .freq0_i(freq0), .freq1_i(freq1),
    .phase0_i(ph0), .phase1_i(ph1),
    .freq_sel_i(fsel), .phase_sel_i(psel),
    .core_reset_i(creset), .clk_halt_i(halt),
    .dac_sleep_i(sleep), .square_en_i(sqen),
    .tri_sel_i(trisel), .square_full_i(sqfull),
    .sample_o(sample), .square_o(square)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp_v);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp_v);
    end
  endtask

  task automatic defaults();
    freq0 = '0; freq1 = '0; ph0 = '0; ph1 = '0;
    fsel = 0; psel = 0; creset = 0; halt = 0;
    sleep = 0; sqen = 0; trisel = 0; sqfull = 1;
  endtask

  // Clear the accumulator with both tuning words at zero, then hold it there.
  task automatic clear_acc();
    freq0 = '0; freq1 = '0;
    creset = 1;
    @(negedge clk);
    creset = 0;
  endtask

  task automatic show_phase(input logic [11:0] p);
    ph0 = p; psel = 0;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic rise_period(output int p);
    logic prev;
    int n;
    p = 0;
    n = 0;
    @(negedge clk);
    prev = square;
    while (n < 4000) begin
      @(negedge clk); n++;
      if (square && !prev) break;
      prev = square;
    end
    prev = square;
    while (p < 4000) begin
      @(negedge clk); p++;
      if (square && !prev) break;
      prev = square;
    end
  endtask

  task automatic t_reset();
    int p;
    defaults();
    rst_n = 0;
    @(negedge clk);
    check(sample == 10'd512, "R1 rst_n sample", sample, 512);
    check(square == 1'b0, "R1 rst_n square", square, 0);
    rst_n = 1;
    freq0 = 28'd1 << 20; trisel = 1; ph0 = 12'h200;
    repeat (5) @(negedge clk);
    creset = 1;
    @(negedge clk);
    check(sample == 10'd512, "R1 core reset sample", sample, 512);
    check(square == 1'b0, "R1 core reset square", square, 0);
    freq0 = '0;
    repeat (2) @(negedge clk);
    creset = 0;
    repeat (2) @(negedge clk);
    check(sample == 10'd256, "R1 accumulator cleared", sample, 256);
    p = 0;
  endtask

  task automatic t_latency();
    defaults(); trisel = 1;
    clear_acc();
    show_phase(12'h200);
    ph0 = 12'h400;
    #1;
    check(sample == 10'd256, "R12 before edge", sample, 256);
    @(negedge clk);
    check(sample == 10'd512, "R12 after one edge", sample, 512);
  endtask

  task automatic t_sine();
    int a, b;
    defaults();
    clear_acc();
    show_phase(12'h000);
    check(sample == 10'd512, "R6 sine phase 0", sample, 512);
    show_phase(12'h400);
    check(sample >= 10'd1018, "R6 sine peak", sample, 1018);
    show_phase(12'hC00);
    check(sample <= 10'd5, "R6 sine trough", sample, 5);
    show_phase(12'h155); a = sample;
    show_phase(12'h955); b = sample;
    check(a + b == 1024, "R7 antisymmetry 0x155", a + b, 1024);
    show_phase(12'h6A3); a = sample;
    show_phase(12'hEA3); b = sample;
    check(a + b == 1024, "R7 antisymmetry 0x6A3", a + b, 1024);
  endtask

  task automatic t_tri();
    defaults(); trisel = 1;
    clear_acc();
    show_phase(12'h000); check(sample == 10'd0,    "R8 tri 0",     sample, 0);
    show_phase(12'h400); check(sample == 10'd512,  "R8 tri 0x400", sample, 512);
    show_phase(12'h7FF); check(sample == 10'd1023, "R8 tri 0x7FF", sample, 1023);
    show_phase(12'hC00); check(sample == 10'd511,  "R8 tri 0xC00", sample, 511);
    show_phase(12'h200); check(sample == 10'd256,  "R8 tri 0x200", sample, 256);
  endtask

  task automatic t_psel();
    defaults(); trisel = 1;
    clear_acc();
    ph0 = 12'h100; ph1 = 12'h600;
    psel = 0; repeat (2) @(negedge clk);
    check(sample == 10'd128, "R4 offset 0", sample, 128);
    psel = 1; repeat (2) @(negedge clk);
    check(sample == 10'd768, "R4 offset 1", sample, 768);
  endtask

  task automatic t_square_sample();
    defaults(); sqen = 1; trisel = 1;
    clear_acc();
    show_phase(12'h800); check(sample == 10'd1023, "R9 square high", sample, 1023);
    show_phase(12'h7FF); check(sample == 10'd0,    "R9 square low",  sample, 0);
  endtask

  task automatic t_freq();
    int p;
    defaults(); sqfull = 1;
    freq0 = 28'd1 << 24;
    rise_period(p); check(p == 16, "R2 period F=2^24", p, 16);
    freq0 = 28'd1 << 22;
    rise_period(p); check(p == 64, "R2 period F=2^22", p, 64);
    freq0 = 28'd1 << 24; sqfull = 0;
    rise_period(p); check(p == 32, "R10 half rate period", p, 32);
  endtask

  task automatic t_fsel();
    int p, changes;
    logic prev;
    defaults();
    clear_acc();
    freq1 = 28'd1 << 24; fsel = 0;
    changes = 0;
    @(negedge clk); prev = square;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (square != prev) changes++;
      prev = square;
    end
    check(changes == 0, "R3 word 0 selected (zero)", changes, 0);
    fsel = 1;
    rise_period(p); check(p == 16, "R3 word 1 selected", p, 16);
  endtask

  task automatic t_halt();
    int p, bad;
    logic [9:0] s0;
    logic q0;
    defaults(); trisel = 1;
    freq0 = 28'd1 << 24;
    repeat (5) @(negedge clk);
    halt = 1;
    repeat (2) @(negedge clk);
    s0 = sample; q0 = square; bad = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (sample != s0 || square != q0) bad++;
    end
    check(bad == 0, "R5 halt freezes outputs", bad, 0);
    halt = 0;
    rise_period(p); check(p == 16, "R5 resume after halt", p, 16);
  endtask

  task automatic t_sleep();
    int p, bad;
    defaults(); sleep = 1; sqen = 1;
    freq0 = 28'd1 << 24;
    repeat (2) @(negedge clk);
    bad = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (sample != 10'd0) bad++;
    end
    check(bad == 0, "R11 sleep mutes sample", bad, 0);
    rise_period(p); check(p == 16, "R11 square runs in sleep", p, 16);
  endtask

  initial begin
    t_reset();
    t_latency();
    t_sine();
    t_tri();
    t_psel();
    t_square_sample();
    t_freq();
    t_fsel();
    t_halt();
    t_sleep();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      vectors++;
      miscompares++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule